// File: doc/BRIEF.md
# Asynchronous PSRAM Access Controller

This block sits between a simple clocked host port and an asynchronous pseudo-static RAM of 128K words by 16 bits. Each host request is a single read or write of one word, with per-byte enables. The controller turns it into a pin-level cycle on the memory. Every phase of that cycle lasts a whole number of clock cycles, and the counts are set by parameters. The memory side uses a split data bus: an output word, an input word and a driver enable. The pad ring joins them.

A pseudo-static RAM hides its own refresh. It can only do this if the host does not keep the chip selected for too long with short read cycles. A guard inside the controller counts the cycles since the chip enable last stayed high for a full read-cycle time. When that count reaches its limit, the controller stops accepting requests. It then holds the chip deselected until a long enough gap has been seen, and resumes after that.

The state machine has six states:
- `ST_IDLE`: deselected; the block accepts requests here.
- `ST_SETUP`: the address is driven while the chip is still deselected.
- `ST_READ`: output enable is low.
- `ST_WRITE`: write enable is low and the data is driven.
- `ST_HOLD`: write enable is high again, while the chip enable and the data stay put.
- `ST_GAP`: a deselect forced by the guard.

The transitions are:
- IDLE→SETUP on an accepted request.
- IDLE→GAP when the guard expires.
- SETUP→READ or SETUP→WRITE when the setup count ends.
- READ→IDLE when the access count ends.
- WRITE→HOLD when the pulse count ends.
- HOLD→IDLE after one cycle.
- GAP→IDLE once the guard clears.

Top module: `psram_ctrl`

## Requirements
- R1: After reset the chip is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle and the guard has not expired, and it is low in the cycle after an acceptance.
- R3: After acceptance the address is driven for exactly SETUP_CYC cycles with the chip deselected before the chip enables go active. The address stays unchanged while the chip is selected.
- R4: A read holds `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles.
- R5: The read word is sampled in the last read cycle and returned on `rsp_rdata` together with a `rsp_valid` pulse one cycle long, in the cycle after the read ends.
- R6: `mem_lb_n` is the inverse of `req_be[0]` (bits 7:0) and `mem_ub_n` is the inverse of `req_be[1]` (bits 15:8), held through the whole selected part of the access. Read lanes whose enable is 0 return zero.
- R7: A write holds `mem_we_n`=0 with both chip enables active and `mem_dq_out` equal to the write data for exactly WR_CYC cycles. It is followed by one hold cycle with `mem_we_n`=1, the chip still selected and the data still driven. The write is therefore always ended by the write-enable edge.
- R8: `mem_dq_oe` is never high while `mem_oe_n` is low, and it has been low for at least one cycle whenever `mem_oe_n` falls.
- R9: The number of cycles between two chip-enable-high runs of at least GAP_CYC cycles never exceeds GUARD_LIMIT plus one access length plus GAP_CYC plus 2. When the guard expires in idle, the controller enters the forced gap with the chip deselected and `req_ready` low.
- R10: A deselected stretch of GAP_CYC or more cycles clears the guard, so sparse traffic never meets a forced gap.
- R11: A write also ends with a single-cycle `rsp_valid` pulse, in the cycle after its hold cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, bit 0 = low byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, disabled lanes zero |
| mem_ce1_n | output | 1 | Memory chip enable, active low |
| mem_ce2 | output | 1 | Memory chip enable, active high |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data toward the memory |
| mem_dq_in | input | DATA_W | Data from the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
The bench first fills sixteen addresses with full-word writes. Every combination of the two byte enables is then written and read back, once as a full word and once masked. This shows whether a single lane is merged correctly, whether an access with no lanes enabled leaves memory alone, and whether disabled read lanes come back as zero. For every access the bench counts the cycles spent in setup, read, write pulse and hold on the pins, and compares them with the parameters.

A long back-to-back read stream must run into a forced deselect within the span bound. The same reads spaced by idle gaps must never be held off, which separates the guard's expiry path from its clearing path.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READ,
        ST_WRITE,
        ST_HOLD,
        ST_GAP
    } psram_state_e;

    function automatic int cyc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_cycle_timer.sv
module psram_cycle_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/psram_refresh_guard.sv
module psram_refresh_guard #(
    parameter int LIMIT   = 1400,
    parameter int GAP_CYC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic selected,
    output logic expired
);

    localparam int BW = $clog2(LIMIT + 1);
    localparam int DW = $clog2(GAP_CYC + 1);

    logic [DW-1:0] run_q, run_d;
    logic [BW-1:0] busy_q;
    logic          gap_done;

    // Length of the current deselected run, saturating at GAP_CYC
    always_comb begin
        if (selected) begin
            run_d = '0;
        end else if (run_q != DW'(GAP_CYC)) begin
            run_d = run_q + 1'b1;
        end else begin
            run_d = run_q;
        end
    end

    assign gap_done = (run_d == DW'(GAP_CYC));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            busy_q <= '0;
        end else begin
            run_q <= run_d;
            if (gap_done) begin
                busy_q <= '0;
            end else if (busy_q != BW'(LIMIT)) begin
                busy_q <= busy_q + 1'b1;
            end
        end
    end

    assign expired = (busy_q == BW'(LIMIT));

    AST_GAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        gap_done |=> !expired); // R10

    AST_EXPIRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && selected) |=> expired); // R9

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 16,
    parameter int SETUP_CYC   = 1,
    parameter int RD_CYC      = 7,
    parameter int WR_CYC      = 6,
    parameter int GAP_CYC     = 7,
    parameter int GUARD_LIMIT = 1400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_be,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                mem_ce1_n,
    output logic                mem_ce2,
    output logic                mem_we_n,
    output logic                mem_oe_n,
    output logic                mem_ub_n,
    output logic                mem_lb_n,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_dq_out,
    input  logic [DATA_W-1:0]   mem_dq_in,
    output logic                mem_dq_oe
);

    localparam int BE_W    = DATA_W / 8;
    localparam int MAX_CYC = cyc_max(cyc_max(SETUP_CYC, RD_CYC), WR_CYC);
    localparam int TMR_W   = $clog2(MAX_CYC + 1);

    psram_state_e        state_q, state_d;
    logic                tmr_load, tmr_zero, guard_exp, accept, rd_last;
    logic [TMR_W-1:0]    tmr_val;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q, rdata_q, lane_mask;
    logic [BE_W-1:0]     be_q;
    logic                write_q, rsp_q;

    generate
        for (genvar g = 0; g < BE_W; g++) begin : g_lane
            assign lane_mask[g*8 +: 8] = {8{be_q[g]}};
        end
    endgenerate

    psram_cycle_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    psram_refresh_guard #(.LIMIT(GUARD_LIMIT), .GAP_CYC(GAP_CYC)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .selected (!mem_ce1_n),
        .expired  (guard_exp)
    );

    assign accept  = (state_q == ST_IDLE) && !guard_exp && req_valid;
    assign rd_last = (state_q == ST_READ) && tmr_zero;

    // Next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (guard_exp) begin
                    state_d = ST_GAP;
                end else if (req_valid) begin
                    state_d  = ST_SETUP;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(SETUP_CYC - 1);
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (write_q) begin
                        state_d = ST_WRITE;
                        tmr_val = TMR_W'(WR_CYC - 1);
                    end else begin
                        state_d = ST_READ;
                        tmr_val = TMR_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ:  if (tmr_zero) state_d = ST_IDLE;
            ST_WRITE: if (tmr_zero) state_d = ST_HOLD;
            ST_HOLD:  state_d = ST_IDLE;
            ST_GAP:   if (!guard_exp) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            write_q <= 1'b0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= rd_last || (state_q == ST_HOLD);
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
                write_q <= req_write;
            end
            if (rd_last) rdata_q <= mem_dq_in & lane_mask;
        end
    end

    // Pin levels per state
    always_comb begin
        mem_ce1_n = 1'b1;
        mem_ce2   = 1'b0;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_ub_n  = 1'b1;
        mem_lb_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_READ: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_oe_n  = 1'b0;
                mem_ub_n  = !be_q[BE_W-1];
                mem_lb_n  = !be_q[0];
            end
            ST_WRITE: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
                mem_ub_n  = !be_q[BE_W-1];
                mem_lb_n  = !be_q[0];
            end
            ST_HOLD: begin
                mem_ce1_n = 1'b0;
                mem_ce2   = 1'b1;
                mem_dq_oe = 1'b1;
                mem_ub_n  = !be_q[BE_W-1];
                mem_lb_n  = !be_q[0];
            end
            ST_IDLE, ST_SETUP, ST_GAP: begin
            end
            default: begin
            end
        endcase
    end

    assign req_ready  = (state_q == ST_IDLE) && !guard_exp;
    assign rsp_valid  = rsp_q;
    assign rsp_rdata  = rdata_q;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce1_n && !mem_ce2)); // R2

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr)); // R3

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R5

    AST_WE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe && mem_oe_n)); // R7

    AST_WE_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce1_n && mem_dq_oe)); // R7

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n)); // R8

    AST_OE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe)); // R8

    AST_GAP_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_exp && state_q == ST_IDLE) |=> (state_q == ST_GAP && mem_ce1_n)); // R9

endmodule

// File: tb/sim_psram_ctrl.sv
module sim_psram_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SETUP_CYC  = 1;
    localparam int RD_CYC     = 4;
    localparam int WR_CYC     = 3;
    localparam int GAP_CYC    = 4;
    localparam int LIMIT      = 60;
    localparam int ACC_MAX    = SETUP_CYC + ((RD_CYC > WR_CYC + 1) ? RD_CYC : WR_CYC + 1);
    localparam int SPAN_MAX   = LIMIT + ACC_MAX + GAP_CYC + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
    logic [16:0] mem_addr;
    logic [15:0] mem_dq_out, mem_dq_in;
    logic        mem_dq_oe;

    int errors = 0;
    int checks = 0;
    logic [15:0] dev_mem [16];
    logic [15:0] exp_mem [16];
    int  hi_run = 0, since_gap = 0, max_span = 0;
    logic measure_on = 1'b0;
    logic fight_seen = 1'b0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psram_ctrl #(
        .ADDR_W(17), .DATA_W(16), .SETUP_CYC(SETUP_CYC), .RD_CYC(RD_CYC),
        .WR_CYC(WR_CYC), .GAP_CYC(GAP_CYC), .GUARD_LIMIT(LIMIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // Memory model: filler values on disabled lanes
    assign mem_dq_in = (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) ?
        {mem_ub_n ? 8'hA5 : dev_mem[mem_addr[3:0]][15:8],
         mem_lb_n ? 8'h5A : dev_mem[mem_addr[3:0]][7:0]} : 16'hFFFF;

    always @(negedge clk) begin
        if (rst_n && !mem_ce1_n && mem_ce2 && !mem_we_n) begin
            if (!mem_lb_n) dev_mem[mem_addr[3:0]][7:0]  <= mem_dq_out[7:0];
            if (!mem_ub_n) dev_mem[mem_addr[3:0]][15:8] <= mem_dq_out[15:8];
        end
    end

    // Pin monitor: guard span and bus contention
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_ce1_n) hi_run = hi_run + 1;
            else           hi_run = 0;
            if (hi_run >= GAP_CYC) since_gap = 0;
            else                   since_gap = since_gap + 1;
            if (measure_on && since_gap > max_span) max_span = since_gap;
            if (mem_dq_oe && !mem_oe_n) fight_seen = 1'b1;
        end
    end

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lanes(input logic [1:0] be);
        return {be[1] ? 8'hFF : 8'h00, be[0] ? 8'hFF : 8'h00};
    endfunction

    function automatic logic [16:0] addr_of(input int a);
        return {13'(a * 611), 4'(a)};
    endfunction

    task automatic access(input logic wr, input logic [16:0] a, input logic [15:0] d,
                          input logic [1:0] be, output logic [15:0] rd,
                          output logic shape_ok, output logic waited);
        int n_set, n_rd, n_we, n_hold, lim;
        n_set = 0; n_rd = 0; n_we = 0; n_hold = 0; lim = 0;
        shape_ok = 1'b1;
        waited = 1'b0;
        while (!req_ready) begin
            waited = 1'b1;
            @(negedge clk);
        end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        check(!req_ready && !rsp_valid, "R2 ready low after accept / R5 no early valid",
              {30'd0, req_ready, rsp_valid}, 32'd0);
        while (!rsp_valid && lim < 100) begin
            if (mem_ce1_n) begin
                n_set++;
                if (mem_addr !== a || n_rd + n_we + n_hold != 0) shape_ok = 1'b0;
            end else begin
                if (mem_addr !== a || mem_ub_n !== !be[1] || mem_lb_n !== !be[0]) shape_ok = 1'b0;
                if (!mem_oe_n && mem_we_n) n_rd++;
                else if (!mem_we_n && mem_oe_n) begin
                    n_we++;
                    if (mem_dq_out !== d || !mem_dq_oe) shape_ok = 1'b0;
                end else if (mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_out === d) n_hold++;
                else shape_ok = 1'b0;
            end
            @(negedge clk);
            lim++;
        end
        rd = rsp_rdata;
        if (lim >= 100) shape_ok = 1'b0;
        if (wr) begin
            if (n_set != SETUP_CYC || n_we != WR_CYC || n_hold != 1 || n_rd != 0) shape_ok = 1'b0;
        end else begin
            if (n_set != SETUP_CYC || n_rd != RD_CYC || n_we != 0 || n_hold != 0) shape_ok = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd, pat;
        logic ok, waited;
        int forced, held_sparse;

        for (int i = 0; i < 16; i++) dev_mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_ce1_n === 1'b1 && mem_ce2 === 1'b0 && mem_we_n === 1'b1 && mem_oe_n === 1'b1
              && mem_dq_oe === 1'b0 && req_ready === 1'b1 && rsp_valid === 1'b0,
              "R1 reset levels",
              {26'd0, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe, req_ready},
              32'b101101);
        rst_n = 1'b1;
        repeat (GAP_CYC + 2) @(negedge clk);

        // Full-word fill, spaced so the guard stays clear
        for (int a = 0; a < 16; a++) begin
            pat = 16'(a * 16'h0F1D + 16'h3C5A);
            access(1'b1, addr_of(a), pat, 2'b11, rd, ok, waited);
            exp_mem[a] = pat;
            check(ok, "R7/R11 full write shape", {31'd0, ok}, 32'd1);
            repeat (GAP_CYC + 1) @(negedge clk);
        end

        // Sweep every byte-enable pattern: lane write, full readback, masked readback
        for (int a = 0; a < 16; a++) begin
            for (int be = 0; be < 4; be++) begin
                pat = ~exp_mem[a] ^ 16'(be * 16'h0101 + a);
                access(1'b1, addr_of(a), pat, 2'(be), rd, ok, waited);
                check(ok, "R6/R7 lane write shape", {31'd0, ok}, 32'd1);
                exp_mem[a] = (exp_mem[a] & ~lanes(2'(be))) | (pat & lanes(2'(be)));
                access(1'b0, addr_of(a), 16'h0, 2'b11, rd, ok, waited);
                check(ok, "R3/R4 read shape", {31'd0, ok}, 32'd1);
                check(rd === exp_mem[a], "R5/R6 full readback after lane write",
                      {16'd0, rd}, {16'd0, exp_mem[a]});
                access(1'b0, addr_of(a), 16'h0, 2'(be), rd, ok, waited);
                check(rd === (exp_mem[a] & lanes(2'(be))), "R6 masked readback",
                      {16'd0, rd}, {16'd0, exp_mem[a] & lanes(2'(be))});
                repeat (GAP_CYC + 1) @(negedge clk);
            end
        end

        // R9: back-to-back reads must hit a forced deselect within the span bound
        forced = 0;
        measure_on = 1'b1;
        for (int n = 0; n < 40; n++) begin
            access(1'b0, addr_of(n % 16), 16'h0, 2'b11, rd, ok, waited);
            if (waited) forced++;
            check(rd === exp_mem[n % 16], "R5 back-to-back read data",
                  {16'd0, rd}, {16'd0, exp_mem[n % 16]});
        end
        measure_on = 1'b0;
        check(forced > 0, "R9 forced gap occurred", forced, 32'd1);
        check(max_span <= SPAN_MAX, "R9 selected span bound", max_span, SPAN_MAX);

        // R10: sparse traffic never waits
        held_sparse = 0;
        repeat (GAP_CYC + 1) @(negedge clk);
        for (int n = 0; n < 20; n++) begin
            access(1'b0, addr_of(n % 16), 16'h0, 2'b11, rd, ok, waited);
            if (waited) held_sparse++;
            repeat (GAP_CYC + 1) @(negedge clk);
        end
        check(held_sparse == 0, "R10 no forced gap with idle stretches", held_sparse, 32'd0);

        check(!fight_seen, "R8 no data drive during output enable", {31'd0, fight_seen}, 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule